// File: doc/BRIEF.md
# Initiator Request Ordering and Burst Expansion Controller

This block sits in the initiator-side network interface between a processing unit and a packet network that carries all traffic to a given destination along one fixed path. It takes requests through a valid/ready handshake. For each accepted request it emits one or more request packets, one per clock, each carrying the routing field, the burst-length code, the write flag, the acknowledge-request flag and a hold-the-path flag. The routing field is derived from the request address.

Read ordering is kept without reorder buffers. Because one destination always uses one path, reads to that destination cannot overtake each other, so several may be in flight at once. A read to any other destination waits until every outstanding read has returned. A request that asks for an acknowledge stalls the initiator until the acknowledge event arrives. A burst is unrolled into consecutive packets whose addresses step by a fixed offset. Every packet of a burst except the last asks the switches to keep the path granted.

Top module: `noc_init_order_ctrl`

## Requirements
- R1: A read whose destination (address bits [31:28]) equals that of the reads still outstanding is accepted at once, with `req_ready` high, while those reads are in flight.
- R2: A read to a different destination while any read is outstanding sees `req_ready` low and `init_hold` high. It becomes ready in the cycle after the response event that brings the outstanding count to zero.
- R3: Accepting a request with `req_ack` set keeps `req_ready` low and `init_hold` high. Both are released in the cycle after an `ack_arrive` pulse.
- R4: `pkt_route` equals {d, ~d, d}, where d is the 4-bit destination in address bits [31:28] of the packet's address.
- R5: Burst code `req_blen` values 0, 1, 2 and 3 give 1, 2, 4 and 8 packets. These appear on consecutive cycles, starting the cycle after acceptance, and `pkt_blen` repeats the code on each of them.
- R6: Packet k of a burst carries address base + 4·k.
- R7: `pkt_cc` is 1 on every packet of a burst except the last, where it is 0. `pkt_ack` is set only on the last packet, and only if the request asked for it.
- R8: A response event arriving in the same cycle as a read acceptance is counted together with it as one net change. The outstanding count stays exact, which shows as the cycle at which a held read is released.
- R9: While the controller holds the initiator and no burst is being unrolled, the header outputs do not change.
- R10: A read is held whenever its beats added to the outstanding count would exceed the counter maximum (31 by default).
- R11: After reset `req_ready` is 1, `pkt_valid` is 0 and `init_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | 32 | Base address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_blen | input | 2 | Burst code: 0..3 gives 1, 2, 4, 8 beats |
| req_ack | input | 1 | Request asks for an acknowledge |
| rsp_arrive | input | 1 | One read response packet returned |
| ack_arrive | input | 1 | Acknowledge packet returned |
| pkt_valid | output | 1 | Request packet on the output this cycle |
| pkt_addr | output | 32 | Beat address |
| pkt_route | output | 12 | Routing field |
| pkt_blen | output | 2 | Burst code |
| pkt_write | output | 1 | Write flag |
| pkt_ack | output | 1 | Acknowledge-request flag |
| pkt_cc | output | 1 | Keep-path-granted flag |
| init_hold | output | 1 | Initiator is being held |

## Verification
A miscounted outstanding-read total shows at the ports within one cycle of the response that should have cleared it. A blocked read stays blocked, or is released one response early, and the bench probes this by checking the ready flag around each response. A lost acknowledge state shows as `req_ready` rising before the acknowledge arrives. A wrong beat counter shows in the next packet, as a misplaced cleared keep-path flag or a wrong address step. Corruption of the stored destination shows as an accepted read to a new destination while reads are still in flight.

// File: rtl/noc_ord_pkg.sv
`timescale 1ns/1ps
package noc_ord_pkg;
  localparam int ROUTE_W = 12;
  localparam int DEST_W  = 4;
  localparam int BEAT_W  = 4;

  function automatic logic [BEAT_W-1:0] beats_of(input logic [1:0] code);
    return BEAT_W'(1) << code;
  endfunction

  function automatic logic [ROUTE_W-1:0] route_of(input logic [DEST_W-1:0] d);
    return {d, ~d, d};
  endfunction
endpackage

// File: rtl/noc_route_map.sv
`timescale 1ns/1ps
module noc_route_map
  import noc_ord_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [DEST_W-1:0]  dest,
  output logic [ROUTE_W-1:0] route
);
  always_comb begin
    dest  = addr[ADDR_W-1 -: DEST_W];
    route = route_of(dest);
  end
endmodule

// File: rtl/noc_burst_seq.sv
`timescale 1ns/1ps
module noc_burst_seq
  import noc_ord_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic               write,
  input  logic [1:0]         blen,
  input  logic               ack,
  input  logic [ROUTE_W-1:0] route,
  output logic               pkt_valid,
  output logic [ADDR_W-1:0]  pkt_addr,
  output logic [ROUTE_W-1:0] pkt_route,
  output logic [1:0]         pkt_blen,
  output logic               pkt_write,
  output logic               pkt_ack,
  output logic               pkt_cc,
  output logic               busy
);
  logic [BEAT_W-1:0] left_q;
  logic              ack_q;
  logic [BEAT_W-1:0] load_beats;

  assign load_beats = beats_of(blen);
  assign busy       = pkt_valid && (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt_addr  <= '0;
      pkt_route <= '0;
      pkt_blen  <= '0;
      pkt_write <= 1'b0;
      pkt_ack   <= 1'b0;
      pkt_cc    <= 1'b0;
      left_q    <= '0;
      ack_q     <= 1'b0;
    end else if (load) begin
      pkt_valid <= 1'b1;
      pkt_addr  <= base_addr;
      pkt_route <= route;
      pkt_blen  <= blen;
      pkt_write <= write;
      ack_q     <= ack;
      left_q    <= load_beats - BEAT_W'(1);
      pkt_cc    <= (load_beats != BEAT_W'(1));
      pkt_ack   <= ack && (load_beats == BEAT_W'(1));
    end else if (busy) begin
      pkt_addr  <= pkt_addr + ADDR_W'(STEP);
      left_q    <= left_q - BEAT_W'(1);
      pkt_cc    <= (left_q != BEAT_W'(1));
      pkt_ack   <= ack_q && (left_q == BEAT_W'(1));
    end else begin
      pkt_valid <= 1'b0;
    end
  end

  // R7 / R6: a packet asking to keep the path is always followed by the next beat
  assert_cc_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_cc && !load) |=> (pkt_valid && pkt_addr == $past(pkt_addr) + ADDR_W'(STEP)));
  // R7: the closing packet of a burst ends the unrolling
  assert_last_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_cc) |-> !busy);
  // R7: acknowledge request only on the closing packet
  assert_ack_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ack) |-> !pkt_cc);
endmodule

// File: rtl/noc_order_gate.sv
`timescale 1ns/1ps
module noc_order_gate
  import noc_ord_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_read,
  input  logic [DEST_W-1:0] req_dest,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_ack,
  input  logic              seq_busy,
  input  logic              rsp_arrive,
  input  logic              ack_arrive,
  output logic              req_ready,
  output logic              hold,
  output logic              accept
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0]  cnt_q;
  logic [DEST_W-1:0] last_dest_q;
  logic              ack_pend_q;
  logic [CNT_W:0]    cnt_plus;
  logic              rd_block, cap_block;
  logic              rd_accept;
  logic [CNT_W:0]    cnt_next;

  always_comb begin
    cnt_plus  = {1'b0, cnt_q} + (CNT_W+1)'(req_beats);
    rd_block  = req_is_read && (cnt_q != '0) && (req_dest != last_dest_q);
    cap_block = req_is_read && (cnt_plus > CNT_MAX);
    req_ready = !seq_busy && !ack_pend_q && !rd_block && !cap_block;
    accept    = req_valid && req_ready;
    rd_accept = accept && req_is_read;
    hold      = ack_pend_q || (req_valid && (rd_block || cap_block));
    cnt_next  = {1'b0, cnt_q}
              + (rd_accept ? (CNT_W+1)'(req_beats) : '0)
              - (rsp_arrive ? (CNT_W+1)'(1) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      last_dest_q <= '0;
      ack_pend_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_next[CNT_W-1:0];
      if (rd_accept) last_dest_q <= req_dest;
      if (accept && req_ack) ack_pend_q <= 1'b1;
      else if (ack_arrive)   ack_pend_q <= 1'b0;
    end
  end

  // R1 / R2: a read joining in-flight reads must share their destination
  assert_same_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && cnt_q != '0) |-> (req_dest == last_dest_q));
  // R10: the outstanding counter never wraps
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> (cnt_q >= $past(cnt_q)) || $past(rsp_arrive));
  // R3: an acknowledged request closes the handshake until the acknowledge
  assert_ack_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_ack) |=> !req_ready);
  // R8: a response with no acceptance lowers the count by exactly one
  assert_net_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_arrive && !rd_accept && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/noc_init_order_ctrl.sv
`timescale 1ns/1ps
module noc_init_order_ctrl
  import noc_ord_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5,
  parameter int STEP   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  input  logic [1:0]         req_blen,
  input  logic               req_ack,
  input  logic               rsp_arrive,
  input  logic               ack_arrive,
  output logic               pkt_valid,
  output logic [ADDR_W-1:0]  pkt_addr,
  output logic [ROUTE_W-1:0] pkt_route,
  output logic [1:0]         pkt_blen,
  output logic               pkt_write,
  output logic               pkt_ack,
  output logic               pkt_cc,
  output logic               init_hold
);
  logic [DEST_W-1:0]  req_dest;
  logic [ROUTE_W-1:0] req_route;
  logic [BEAT_W-1:0]  req_beats;
  logic               seq_busy;
  logic               accept;

  assign req_beats = beats_of(req_blen);

  noc_route_map #(.ADDR_W(ADDR_W)) u_map (
    .addr (req_addr),
    .dest (req_dest),
    .route(req_route)
  );

  noc_order_gate #(.CNT_W(CNT_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_read(!req_write),
    .req_dest   (req_dest),
    .req_beats  (req_beats),
    .req_ack    (req_ack),
    .seq_busy   (seq_busy),
    .rsp_arrive (rsp_arrive),
    .ack_arrive (ack_arrive),
    .req_ready  (req_ready),
    .hold       (init_hold),
    .accept     (accept)
  );

  noc_burst_seq #(.ADDR_W(ADDR_W), .STEP(STEP)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .base_addr(req_addr),
    .write    (req_write),
    .blen     (req_blen),
    .ack      (req_ack),
    .route    (req_route),
    .pkt_valid(pkt_valid),
    .pkt_addr (pkt_addr),
    .pkt_route(pkt_route),
    .pkt_blen (pkt_blen),
    .pkt_write(pkt_write),
    .pkt_ack  (pkt_ack),
    .pkt_cc   (pkt_cc),
    .busy     (seq_busy)
  );

  // R9: held with no burst in progress means the header does not move
  assert_hdr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_hold && !seq_busy) |=> ($stable(pkt_addr) && $stable(pkt_route) &&
                                  $stable(pkt_cc) && $stable(pkt_blen)));
  // R4: the route on the wire matches the destination of the wire address
  assert_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_route == route_of(pkt_addr[ADDR_W-1 -: DEST_W])));
endmodule

// File: tb/tb_noc_init_order_ctrl.sv
`timescale 1ns/1ps
module tb_noc_init_order_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ack = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_blen = '0;
  logic        rsp_arrive = 1'b0, ack_arrive = 1'b0;
  logic        req_ready, pkt_valid, pkt_write, pkt_ack, pkt_cc, init_hold;
  logic [31:0] pkt_addr;
  logic [11:0] pkt_route;
  logic [1:0]  pkt_blen;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  noc_init_order_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_blen(req_blen), .req_ack(req_ack),
    .rsp_arrive(rsp_arrive), .ack_arrive(ack_arrive), .pkt_valid(pkt_valid),
    .pkt_addr(pkt_addr), .pkt_route(pkt_route), .pkt_blen(pkt_blen),
    .pkt_write(pkt_write), .pkt_ack(pkt_ack), .pkt_cc(pkt_cc), .init_hold(init_hold)
  );

  function automatic logic [11:0] exp_route(input logic [31:0] a);
    logic [3:0] d = a[31:28];
    return {d, ~d, d};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_rsp(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rsp_arrive = 1'b1;
      @(posedge clk); #1 rsp_arrive = 1'b0;
    end
  endtask

  // present a request that must be accepted at once, then check every packet
  task automatic issue(input logic [31:0] a, input bit w, input logic [1:0] bl,
                       input bit ac, input bit rsp_same, input string req);
    int nb = 1 << bl;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_blen = bl; req_ack = ac;
    rsp_arrive = rsp_same;
    #1 chk(req_ready == 1'b1, req, "ready at issue", req_ready, 1);
    @(posedge clk); #1 req_valid = 1'b0; rsp_arrive = 1'b0;
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      chk(pkt_valid == 1'b1 && pkt_blen == bl && pkt_write == w, "R5", "beat present",
          {pkt_valid, pkt_blen, pkt_write}, {1'b1, bl, w});
      chk(pkt_addr == a + 32'(4 * k), "R6", "beat address", pkt_addr, a + 32'(4 * k));
      chk(pkt_cc == (k != nb - 1) && pkt_ack == (ac && k == nb - 1), "R7", "cc/ack flags",
          {pkt_cc, pkt_ack}, {(k != nb - 1), (ac && k == nb - 1)});
      chk(pkt_route == exp_route(a), "R4", "route field", pkt_route, exp_route(a));
    end
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R5", "no extra beat", pkt_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1 && pkt_valid == 0 && init_hold == 0, "R11", "reset state",
        {req_ready, pkt_valid, init_hold}, 3'b100);
  endtask

  task automatic t_bursts();
    issue(32'h3000_0010, 1'b1, 2'd2, 1'b0, 1'b0, "R5");
    issue(32'hA000_0100, 1'b1, 2'd3, 1'b0, 1'b0, "R6");
    issue(32'h4000_0020, 1'b0, 2'd0, 1'b0, 1'b0, "R5");
    pulse_rsp(1);
  endtask

  task automatic t_same_dest();
    issue(32'h5000_0000, 1'b0, 2'd1, 1'b0, 1'b0, "R1");
    issue(32'h5000_0400, 1'b0, 2'd0, 1'b0, 1'b0, "R1");
    pulse_rsp(3);
  endtask

  task automatic t_diff_dest();
    logic [31:0] a0;
    logic [11:0] r0;
    issue(32'h5000_0000, 1'b0, 2'd0, 1'b0, 1'b0, "R2");
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h6000_0000; req_write = 1'b0; req_blen = 2'd0; req_ack = 1'b0;
    #1 chk(req_ready == 0 && init_hold == 1, "R2", "blocked read", {req_ready, init_hold}, 2'b01);
    a0 = pkt_addr; r0 = pkt_route;
    repeat (3) @(negedge clk);
    chk(req_ready == 0, "R2", "still blocked", req_ready, 0);
    chk(pkt_addr == a0 && pkt_route == r0, "R9", "header stable", pkt_addr, a0);
    rsp_arrive = 1'b1;
    @(posedge clk); #1 rsp_arrive = 1'b0;
    @(negedge clk);
    chk(req_ready == 1 && init_hold == 0, "R2", "released", {req_ready, init_hold}, 2'b10);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(pkt_valid == 1 && pkt_route == exp_route(32'h6000_0000), "R2", "new dest packet",
        pkt_route, exp_route(32'h6000_0000));
    pulse_rsp(1);
  endtask

  task automatic t_ack();
    issue(32'h2000_0040, 1'b1, 2'd1, 1'b1, 1'b0, "R3");
    repeat (4) @(negedge clk);
    chk(req_ready == 0 && init_hold == 1, "R3", "held for ack", {req_ready, init_hold}, 2'b01);
    ack_arrive = 1'b1;
    @(posedge clk); #1 ack_arrive = 1'b0;
    @(negedge clk);
    chk(req_ready == 1 && init_hold == 0, "R3", "resumed", {req_ready, init_hold}, 2'b10);
  endtask

  task automatic t_net();
    issue(32'h7000_0000, 1'b0, 2'd1, 1'b0, 1'b0, "R8");
    issue(32'h7000_0100, 1'b0, 2'd0, 1'b0, 1'b1, "R8");
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h8000_0000; req_write = 1'b0; req_blen = 2'd0;
    #1 chk(req_ready == 0, "R8", "two left", req_ready, 0);
    rsp_arrive = 1'b1;
    @(posedge clk); #1 rsp_arrive = 1'b0;
    @(negedge clk);
    chk(req_ready == 0, "R8", "one left", req_ready, 0);
    rsp_arrive = 1'b1;
    @(posedge clk); #1 rsp_arrive = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    #1 chk(req_ready == 1, "R8", "count zero", req_ready, 1);
    req_valid = 1'b0;
  endtask

  task automatic t_cap();
    for (int i = 0; i < 3; i++) issue(32'h1000_0000 + 32'(i * 64), 1'b0, 2'd3, 1'b0, 1'b0, "R10");
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h1000_1000; req_write = 1'b0; req_blen = 2'd3;
    #1 chk(req_ready == 0 && init_hold == 1, "R10", "would exceed 31", {req_ready, init_hold}, 2'b01);
    rsp_arrive = 1'b1;
    @(posedge clk); #1 rsp_arrive = 1'b0;
    @(negedge clk);
    chk(req_ready == 1, "R10", "fits exactly 31", req_ready, 1);
    req_valid = 1'b0;
    pulse_rsp(23);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h9000_0000; req_blen = 2'd0;
    #1 chk(req_ready == 1, "R10", "drained", req_ready, 1);
    req_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_bursts();
    t_same_dest();
    t_diff_dest();
    t_ack();
    t_net();
    t_cap();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule